// File: doc/BRIEF.md
# Down-Counting Interval Timer with Maskable Interrupt

This block counts down from a value that software loads, one step for each enabled tick. A tick that takes the count from 1 to 0 is a time-out. A time-out sets a sticky status flag, and the flag becomes visible in the next cycle. Software clears the flag by writing a one to the clear port. If auto-reload is on, the counter starts again from the last loaded value. If auto-reload is off, the counter rests at zero.

The core samples the status flag at the start of each cycle. When the flag is set, the timer's own interrupt enable is set and the core's external-interrupt enable is set, the block asserts a one-cycle take pulse in that same cycle. During that cycle it also presents the address of the next sequential instruction as the return address to save. A request that arrives while it is masked stays pending and is taken as soon as both enables are high. The tick source, other timers and vector formation lie outside the block.

Top module: `pit_irq`

## Requirements
- R1: `irq_take` is never 1 unless `tmr_ctrl[0]` (timer interrupt enable) and `core_ext_en` are both 1 in that cycle.
- R2: A load writes `load_value` into the counter at the next edge, and the load takes priority over a tick in the same cycle. Otherwise each cycle with `tick`=1 and a nonzero count lowers the count by exactly one.
- R3: `status` becomes 1 in the cycle that follows the edge where a tick takes the count from 1 to 0. With a load of N and a tick every P-th cycle, `status` first reads 1 after N*P edges.
- R4: `irq_take` is asserted in the same cycle in which a set, untaken `status` is seen with both enables high. `save_addr` equals `next_pc` while `irq_take` is 1 and is 0 at all other times.
- R5: With `tmr_ctrl[1]` (auto-reload) at 0, the counter stays at 0 after a time-out, and further ticks never set `status` again.
- R6: Loading a count of 0 never sets `status`, however many ticks follow.
- R7: With `tmr_ctrl[1]` at 1, a time-out reloads the counter from the last loaded value, so time-outs repeat every N enabled ticks.
- R8: `status` is cleared only by a cycle with `clr_valid`=1 and `clr_bit`=1. Writing 0 has no effect. A time-out in the same cycle as a clear leaves `status` at 1.
- R9: After reset the count is 0, `status` is 0, `irq_take` is 0 and `save_addr` is 0.
- R10: `irq_take` pulses once per time-out. A time-out that occurs while masked is taken in the first cycle in which both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe from the time base |
| load_valid | input | 1 | Write the count and the reload value |
| load_value | input | CNT_W | Count to load |
| tmr_ctrl | input | 2 | Bit 0: timer interrupt enable. Bit 1: auto-reload enable |
| core_ext_en | input | 1 | Core external-interrupt enable |
| clr_valid | input | 1 | Status write strobe |
| clr_bit | input | 1 | Status write data (1 clears) |
| next_pc | input | CNT_W | Address of the next sequential instruction |
| status | output | 1 | Sticky time-out flag |
| irq_take | output | 1 | One-cycle interrupt-take pulse |
| save_addr | output | CNT_W | Return address to save, valid with `irq_take` |

## Verification
The bench sweeps load values against several tick spacings. A counter that is off by one in the decrement, or that sets the flag one edge early or one edge late, moves the rising edge of `status` away from N*P and fails the sweep. A zero load and the rest state after a time-out without reload are checked to stay quiet; a design that wraps below zero would raise a spurious flag. The bench places a clear in the same cycle as a reload time-out, and a design that lets the clear win drops the flag. The bench also holds a masked request and then opens the enables one at a time. This catches a take that ignores one of the enables, a take that is delayed by a cycle, a take that repeats on every cycle, and a wrong `save_addr`.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PIT_CNT_W = 32;
  localparam int unsigned CTRL_IRQ_EN = 0;
  localparam int unsigned CTRL_RELOAD = 1;
endpackage

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W = pit_pkg::PIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic             reload_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             cnt_en, rld_en;

  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = load_value;
    rld_en = load_valid;
    cnt_en = 1'b0;
    expire = 1'b0;
    if (load_valid) begin
      cnt_d  = load_value;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      if (cnt_q == ONE) begin
        expire = 1'b1;
        cnt_d  = reload_en ? rld_q : '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rld_en) rld_q <= rld_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pit_status.sv
module pit_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_valid,
  input  logic clr_bit,
  input  logic irq_en,
  input  logic core_ext_en,
  output logic status,
  output logic take
);
  logic sts_q, sts_d;
  logic taken_q, taken_d;
  logic clr;

  always_comb begin
    clr  = clr_valid && clr_bit;
    take = sts_q && !taken_q && irq_en && core_ext_en;

    sts_d = sts_q;
    if (expire)   sts_d = 1'b1;
    else if (clr) sts_d = 1'b0;

    taken_d = taken_q;
    if (expire)                  taken_d = 1'b0;
    else if (take)               taken_d = 1'b1;
    else if (clr && !sts_d)      taken_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      taken_q <= taken_d;
    end
  end

  assign status = sts_q;
endmodule

// File: rtl/pit_irq.sv
module pit_irq #(
  parameter int unsigned CNT_W = pit_pkg::PIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic [1:0]       tmr_ctrl,
  input  logic             core_ext_en,
  input  logic             clr_valid,
  input  logic             clr_bit,
  input  logic [CNT_W-1:0] next_pc,
  output logic             status,
  output logic             irq_take,
  output logic [CNT_W-1:0] save_addr
);
  logic [CNT_W-1:0] count;
  logic             expire;

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_valid (load_valid),
    .load_value (load_value),
    .reload_en  (tmr_ctrl[pit_pkg::CTRL_RELOAD]),
    .count      (count),
    .expire     (expire)
  );

  pit_status u_sts (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .clr_valid   (clr_valid),
    .clr_bit     (clr_bit),
    .irq_en      (tmr_ctrl[pit_pkg::CTRL_IRQ_EN]),
    .core_ext_en (core_ext_en),
    .status      (status),
    .take        (irq_take)
  );

  assign save_addr = irq_take ? next_pc : '0;
endmodule

// File: rtl/pit_irq_chk.sv
module pit_irq_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load_valid,
  input logic [CNT_W-1:0] load_value,
  input logic [1:0]       tmr_ctrl,
  input logic             core_ext_en,
  input logic             clr_valid,
  input logic             clr_bit,
  input logic [CNT_W-1:0] next_pc,
  input logic             status,
  input logic             irq_take,
  input logic [CNT_W-1:0] save_addr,
  input logic [CNT_W-1:0] count
);
  a_r1_take_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (tmr_ctrl[0] && core_ext_en));

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (count == $past(load_value)));

  a_r2_tick_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && tick && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

  a_r4_addr_with_take: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (save_addr == next_pc && status));

  a_r5_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_valid) |=> (count == '0));

  a_r8_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !(clr_valid && clr_bit)) |=> status);

  a_r8_rise_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> ($past(count) == CNT_W'(1) && $past(tick) && !$past(load_valid)));

  a_r10_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !(tick && count == CNT_W'(1))) |=> !irq_take);
endmodule

bind pit_irq pit_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .load_valid  (load_valid),
  .load_value  (load_value),
  .tmr_ctrl    (tmr_ctrl),
  .core_ext_en (core_ext_en),
  .clr_valid   (clr_valid),
  .clr_bit     (clr_bit),
  .next_pc     (next_pc),
  .status      (status),
  .irq_take    (irq_take),
  .save_addr   (save_addr),
  .count       (count)
);

// File: tb/pit_irq_tb.sv
module pit_irq_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick, load_valid, core_ext_en, clr_valid, clr_bit;
  logic [W-1:0] load_value, next_pc;
  logic [1:0]   tmr_ctrl;
  logic         status, irq_take;
  logic [W-1:0] save_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_irq #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_valid(load_valid),
    .load_value(load_value), .tmr_ctrl(tmr_ctrl), .core_ext_en(core_ext_en),
    .clr_valid(clr_valid), .clr_bit(clr_bit), .next_pc(next_pc),
    .status(status), .irq_take(irq_take), .save_addr(save_addr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_valid = 1'b1; load_value = v; tick = 1'b0;
    cyc();
    load_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr_valid = 1'b1; clr_bit = 1'b1; tick = 1'b0;
    cyc();
    clr_valid = 1'b0; clr_bit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; load_valid = 1'b0; load_value = '0;
    tmr_ctrl = 2'b00; core_ext_en = 1'b0; clr_valid = 1'b0; clr_bit = 1'b0;
    next_pc = 32'h0000_1000;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R9: reset state
    check(status == 1'b0, "R9 status", status, 0);
    check(irq_take == 1'b0, "R9 take", irq_take, 0);
    check(save_addr == '0, "R9 save_addr", save_addr, 0);

    // R3, R2, R1: sweep count and tick spacing, interrupt masked
    tmr_ctrl = 2'b01; core_ext_en = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      for (int p = 1; p <= 3; p++) begin
        bit bad = 1'b0;
        bit take_seen = 1'b0;
        do_load(W'(n));
        for (int k = 1; k <= n * p + 2; k++) begin
          tick = ((k % p) == 0);
          cyc();
          if (status != (k >= n * p)) bad = 1'b1;
          if (irq_take) take_seen = 1'b1;
        end
        tick = 1'b0;
        check(!bad, "R3 status edge at N*P", n, p);
        check(!take_seen, "R1 masked by core enable", 1, 0);
        do_clear();
      end
    end

    // R5: no reload, rest at zero after time-out
    tmr_ctrl = 2'b00;
    begin
      bit bad = 1'b0;
      for (int k = 0; k < 12; k++) begin
        tick = 1'b1; cyc();
        if (status) bad = 1'b1;
      end
      tick = 1'b0;
      check(!bad, "R5 no second time-out", status, 0);
    end

    // R6: zero load stays quiet
    do_load('0);
    begin
      bit bad = 1'b0;
      for (int k = 0; k < 12; k++) begin
        tick = 1'b1; cyc();
        if (status) bad = 1'b1;
      end
      tick = 1'b0;
      check(!bad, "R6 zero load", status, 0);
    end

    // R8: write of 0 has no effect, write of 1 clears
    do_load(W'(2));
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    check(status == 1'b1, "R8 set before clear", status, 1);
    clr_valid = 1'b1; clr_bit = 1'b0; cyc(); clr_valid = 1'b0;
    check(status == 1'b1, "R8 write zero ignored", status, 1);
    do_clear();
    check(status == 1'b0, "R8 write one clears", status, 0);

    // R7 and R8: auto-reload period and set-wins collision
    tmr_ctrl = 2'b10;
    do_load(W'(3));
    begin
      bit bad = 1'b0;
      for (int k = 1; k <= 3; k++) begin
        tick = 1'b1; cyc();
        if (status != (k == 3)) bad = 1'b1;
      end
      check(!bad, "R7 first period", status, 1);
      // ticks 4,5 quiet count; clear lands with tick 6 (second time-out)
      tick = 1'b1; cyc(); cyc();
      clr_valid = 1'b1; clr_bit = 1'b1; cyc();
      clr_valid = 1'b0; clr_bit = 1'b0;
      check(status == 1'b1, "R8 time-out beats clear", status, 1);
      tick = 1'b0;
      do_clear();
      check(status == 1'b0, "R7 cleared between periods", status, 0);
      tick = 1'b1; cyc(); cyc();
      check(status == 1'b0, "R7 not yet", status, 0);
      cyc();
      check(status == 1'b1, "R7 third period", status, 1);
      tick = 1'b0;
    end

    // R1, R4, R10: pending masked request then taken
    tmr_ctrl = 2'b10; core_ext_en = 1'b1; #1;
    check(irq_take == 1'b0, "R1 timer enable off", irq_take, 0);
    tmr_ctrl = 2'b01; core_ext_en = 1'b0; #1;
    check(irq_take == 1'b0, "R1 core enable off", irq_take, 0);
    cyc(); cyc();
    next_pc = 32'hCAFE_0104;
    core_ext_en = 1'b1; #1;
    check(irq_take == 1'b1, "R10 pending taken at once", irq_take, 1);
    check(save_addr == 32'hCAFE_0104, "R4 save_addr", save_addr, 32'hCAFE_0104);
    cyc();
    check(irq_take == 1'b0, "R10 single pulse", irq_take, 0);
    check(save_addr == '0, "R4 save_addr idle", save_addr, 0);
    check(status == 1'b1, "R8 take does not clear", status, 1);
    do_clear();

    // R4, R10: fresh time-out with both enables taken the cycle status shows
    tmr_ctrl = 2'b01; core_ext_en = 1'b1; next_pc = 32'h0000_2220;
    do_load(W'(2));
    tick = 1'b1; cyc();
    check(irq_take == 1'b0, "R4 no early take", irq_take, 0);
    cyc(); tick = 1'b0;
    check(irq_take == 1'b1 && status, "R4 take with status", irq_take, 1);
    check(save_addr == 32'h0000_2220, "R4 return address", save_addr, 32'h0000_2220);
    cyc();
    check(irq_take == 1'b0, "R10 no repeat", irq_take, 0);

    // R2: load beats tick
    do_clear();
    load_valid = 1'b1; load_value = W'(2); tick = 1'b1; cyc();
    load_valid = 1'b0; tick = 1'b1; cyc();
    check(status == 1'b0, "R2 load over tick", status, 0);
    cyc(); tick = 1'b0;
    check(status == 1'b1, "R2 two ticks after load", status, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule